// File: doc/BRIEF.md
# Multi-Channel Interrupt Bid Arbiter

This block chooses which of several serial channels gets the processor's attention when more than one of them wants it. Each channel can raise six kinds of interrupt request: transmit, receive, change of state on an input pin, Xon/Xoff flow-control event, address-character match and line break. Every unmasked request bids with a number. The upper bits of that number come from a three-bit priority value that software programs per channel and per request kind. The lower bits are the channel number. The highest bid wins.

While any unmasked request is active, the block pulls an active-low interrupt line low. When the host acknowledges, the block records a snapshot of the current winner: its channel, a two-bit class code and a three-bit code for the remaining kinds. It also builds an interrupt vector from a base value. A mode input selects whether the channel number, and then also the class code, is written over the low bits of the vector. The snapshot stays unchanged until the next acknowledge.

Top module: `irq_bid_arbiter`

## Requirements
- R1: An unmasked request of kind t on channel c bids {P, c}, where P is the 3-bit priority at bid_msb_i[(c*6+t)*3 +: 3]. The request bit is req_i[c*6+t]. Kind indices are: transmit 0, receive 1, change of state 2, address match 3, Xon/Xoff 4, break 5. The highest bid is the winner.
- R2: When the priority fields of two channels' best requests are equal, the higher channel number wins.
- R3: Within one channel, requests with equal priority fields are ordered by kind index, and the higher index wins (break highest, transmit lowest).
- R4: A request whose mask_i bit is 0 neither bids nor pulls the interrupt line low.
- R5: irq_n_o is low in the cycle after any unmasked request is present. It stays low while any unmasked request remains, including after an acknowledge. It goes high in the cycle after none is present.
- R6: On a clock edge with iack_i high, cur_valid_o, cur_ch_o, cur_class_o, cur_other_o and vector_o take the values for the current winner. They hold their values on every edge without iack_i.
- R7: The class code is 01 for transmit, 10 for receive and 00 for all other kinds. The other-kind code is 001 for change of state, 010 for Xon/Xoff, 011 for address match, 100 for break, and 000 for transmit, receive or no interrupt.
- R8: The vector mode selects how the vector is built. Mode 0 gives the base value unchanged. Mode 1 writes the winner's channel over bits 2:0. Modes 2 and 3 also write the class code over bits 4:3.
- R9: An acknowledge when no unmasked request is present records valid 0, channel 0, class 00 and other-kind code 000. The vector is built from those zero fields.
- R10: After reset, irq_n_o is 1 and all the recorded outputs, including the vector, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NCH*6 | Request bits, channel-major, kind-minor |
| mask_i | input | NCH*6 | Enable bits, same layout as req_i |
| bid_msb_i | input | NCH*6*MSB_W | Priority field per channel and kind |
| iack_i | input | 1 | Acknowledge strobe, samples the winner |
| vmode_i | input | 2 | Vector build mode |
| vec_base_i | input | VEC_W | Base vector value |
| irq_n_o | output | 1 | Active-low interrupt request |
| cur_valid_o | output | 1 | Recorded winner was a real request |
| cur_ch_o | output | CH_W | Recorded winning channel |
| cur_class_o | output | 2 | Recorded class code |
| cur_other_o | output | 3 | Recorded other-kind code |
| vector_o | output | VEC_W | Recorded interrupt vector |

## Verification
A lone request checks that the recorded codes are correct. Pairs of requests then separate the three ordering rules: priority fields that differ across channels (the field must dominate the channel number), equal fields across channels (the channel decides), and equal fields inside one channel (the kind index decides). A high bid with its mask bit cleared, and a set of requests that are all masked, show that masking removes the bid and the interrupt line. Changing requests without an acknowledge, acknowledging while requests remain, and running all four vector modes on one winner check the snapshot hold, the line staying low, and each vector field substitution.

// File: rtl/irqarb_pkg.sv
// Package: shared constants and code mappings for the interrupt bid arbiter.
// Assumes six request kinds, indexed so that a higher index wins a tie.
package irqarb_pkg;

    localparam int NTYPE  = 6;
    localparam int TYPE_W = 3;

    localparam logic [TYPE_W-1:0] K_TX   = 3'd0;
    localparam logic [TYPE_W-1:0] K_RX   = 3'd1;
    localparam logic [TYPE_W-1:0] K_COS  = 3'd2;
    localparam logic [TYPE_W-1:0] K_ADR  = 3'd3;
    localparam logic [TYPE_W-1:0] K_XON  = 3'd4;
    localparam logic [TYPE_W-1:0] K_BRK  = 3'd5;

    // Two-bit class code written into vector bits above the channel field.
    function automatic logic [1:0] class_of(input logic [TYPE_W-1:0] k);
        case (k)
            K_TX:    class_of = 2'b01;
            K_RX:    class_of = 2'b10;
            default: class_of = 2'b00;
        endcase
    endfunction

    // Three-bit code for the kinds that are neither transmit nor receive.
    function automatic logic [2:0] other_of(input logic [TYPE_W-1:0] k);
        case (k)
            K_COS:   other_of = 3'b001;
            K_XON:   other_of = 3'b010;
            K_ADR:   other_of = 3'b011;
            K_BRK:   other_of = 3'b100;
            default: other_of = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/irqarb_chan_pick.sv
// Module: picks the strongest unmasked request inside one channel.
// Ordering key is {priority field, kind index}; assumes kind index < 2**TYPE_W.
module irqarb_chan_pick
    import irqarb_pkg::*;
#(
    parameter int MSB_W = 3
) (
    input  logic [NTYPE-1:0]       req_i,
    input  logic [NTYPE-1:0]       mask_i,
    input  logic [NTYPE*MSB_W-1:0] msb_i,
    output logic                   has_o,
    output logic [MSB_W-1:0]       msb_o,
    output logic [TYPE_W-1:0]      kind_o
);

    // Linear scan over the kinds keeping the largest {priority, kind} key.
    always_comb begin
        logic                  found;
        logic [MSB_W-1:0]      best_msb;
        logic [TYPE_W-1:0]     best_kind;
        logic [MSB_W-1:0]      cand;
        found     = 1'b0;
        best_msb  = '0;
        best_kind = '0;
        for (int t = 0; t < NTYPE; t++) begin
            cand = msb_i[t*MSB_W +: MSB_W];
            if (req_i[t] && mask_i[t]) begin
                if (!found || {cand, TYPE_W'(t)} > {best_msb, best_kind}) begin
                    best_msb  = cand;
                    best_kind = TYPE_W'(t);
                end
                found = 1'b1;
            end
        end
        has_o  = found;
        msb_o  = best_msb;
        kind_o = best_kind;
    end

endmodule

// File: rtl/irqarb_max.sv
// Module: selects the winning channel from per-channel best bids.
// The bid is {priority field, channel}; scanning upward with >= lets the higher
// channel win when priority fields tie. Assumes channel numbers fit in CH_W bits.
module irqarb_max
    import irqarb_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int MSB_W = 3,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic [NCH-1:0]        has_i,
    input  logic [NCH*MSB_W-1:0]  msb_i,
    input  logic [NCH*TYPE_W-1:0] kind_i,
    output logic                  win_valid_o,
    output logic [CH_W-1:0]       win_ch_o,
    output logic [TYPE_W-1:0]     win_kind_o
);

    // Running maximum across channels; ties go to the later (higher) channel.
    always_comb begin
        logic              found;
        logic [MSB_W-1:0]  best_msb;
        logic [CH_W-1:0]   best_ch;
        logic [TYPE_W-1:0] best_kind;
        found     = 1'b0;
        best_msb  = '0;
        best_ch   = '0;
        best_kind = '0;
        for (int c = 0; c < NCH; c++) begin
            if (has_i[c]) begin
                if (!found || msb_i[c*MSB_W +: MSB_W] >= best_msb) begin
                    best_msb  = msb_i[c*MSB_W +: MSB_W];
                    best_ch   = CH_W'(c);
                    best_kind = kind_i[c*TYPE_W +: TYPE_W];
                end
                found = 1'b1;
            end
        end
        win_valid_o = found;
        win_ch_o    = best_ch;
        win_kind_o  = best_kind;
    end

endmodule

// File: rtl/irqarb_cur_reg.sv
// Module: holds the acknowledged winner, builds the vector, drives the IRQ line.
// Assumes VEC_W >= CH_W + 2 so the class field fits above the channel field.
module irqarb_cur_reg
    import irqarb_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_i,
    input  logic              win_valid_i,
    input  logic [CH_W-1:0]   win_ch_i,
    input  logic [TYPE_W-1:0] win_kind_i,
    input  logic              iack_i,
    input  logic [1:0]        vmode_i,
    input  logic [VEC_W-1:0]  vec_base_i,
    output logic              irq_n_o,
    output logic              cur_valid_o,
    output logic [CH_W-1:0]   cur_ch_o,
    output logic [1:0]        cur_class_o,
    output logic [2:0]        cur_other_o,
    output logic [VEC_W-1:0]  vector_o
);

    localparam int CLS_LO = CH_W;

    logic [CH_W-1:0]  nxt_ch;
    logic [1:0]       nxt_cls;
    logic [2:0]       nxt_oth;
    logic [VEC_W-1:0] nxt_vec;

    // Fields of the next snapshot; all zero when nothing is pending.
    always_comb begin
        nxt_ch  = win_valid_i ? win_ch_i : '0;
        nxt_cls = win_valid_i ? class_of(win_kind_i) : 2'b00;
        nxt_oth = win_valid_i ? other_of(win_kind_i) : 3'b000;
        nxt_vec = vec_base_i;
        if (vmode_i != 2'd0) nxt_vec[CH_W-1:0] = nxt_ch;
        if (vmode_i[1])      nxt_vec[CLS_LO +: 2] = nxt_cls;
    end

    // Registered interrupt line, low while any unmasked request exists.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_o <= 1'b1;
        else        irq_n_o <= ~any_i;
    end

    // Snapshot of the winner, taken only on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid_o <= 1'b0;
            cur_ch_o    <= '0;
            cur_class_o <= 2'b00;
            cur_other_o <= 3'b000;
            vector_o    <= '0;
        end else if (iack_i) begin
            cur_valid_o <= win_valid_i;
            cur_ch_o    <= nxt_ch;
            cur_class_o <= nxt_cls;
            cur_other_o <= nxt_oth;
            vector_o    <= nxt_vec;
        end
    end

endmodule

// File: rtl/irq_bid_arbiter.sv
// Top: interrupt bid arbiter over NCH channels with six request kinds each.
// Per-channel pickers feed a cross-channel maximum; the result is sampled on
// acknowledge. Assumes requests are level signals cleared by their sources.
module irq_bid_arbiter
    import irqarb_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int MSB_W = 3,
    parameter int VEC_W = 8,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH*NTYPE-1:0]       req_i,
    input  logic [NCH*NTYPE-1:0]       mask_i,
    input  logic [NCH*NTYPE*MSB_W-1:0] bid_msb_i,
    input  logic                       iack_i,
    input  logic [1:0]                 vmode_i,
    input  logic [VEC_W-1:0]           vec_base_i,
    output logic                       irq_n_o,
    output logic                       cur_valid_o,
    output logic [CH_W-1:0]            cur_ch_o,
    output logic [1:0]                 cur_class_o,
    output logic [2:0]                 cur_other_o,
    output logic [VEC_W-1:0]           vector_o
);

    localparam int FLD_W = NTYPE * MSB_W;

    logic [NCH-1:0]        ch_has;
    logic [NCH*MSB_W-1:0]  ch_msb;
    logic [NCH*TYPE_W-1:0] ch_kind;
    logic                  win_valid;
    logic [CH_W-1:0]       win_ch;
    logic [TYPE_W-1:0]     win_kind;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        irqarb_chan_pick #(.MSB_W(MSB_W)) u_pick (
            .req_i  (req_i[c*NTYPE +: NTYPE]),
            .mask_i (mask_i[c*NTYPE +: NTYPE]),
            .msb_i  (bid_msb_i[c*FLD_W +: FLD_W]),
            .has_o  (ch_has[c]),
            .msb_o  (ch_msb[c*MSB_W +: MSB_W]),
            .kind_o (ch_kind[c*TYPE_W +: TYPE_W])
        );
    end

    irqarb_max #(.NCH(NCH), .MSB_W(MSB_W), .CH_W(CH_W)) u_max (
        .has_i       (ch_has),
        .msb_i       (ch_msb),
        .kind_i      (ch_kind),
        .win_valid_o (win_valid),
        .win_ch_o    (win_ch),
        .win_kind_o  (win_kind)
    );

    irqarb_cur_reg #(.CH_W(CH_W), .VEC_W(VEC_W)) u_cur (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_i       (|ch_has),
        .win_valid_i (win_valid),
        .win_ch_i    (win_ch),
        .win_kind_i  (win_kind),
        .iack_i      (iack_i),
        .vmode_i     (vmode_i),
        .vec_base_i  (vec_base_i),
        .irq_n_o     (irq_n_o),
        .cur_valid_o (cur_valid_o),
        .cur_ch_o    (cur_ch_o),
        .cur_class_o (cur_class_o),
        .cur_other_o (cur_other_o),
        .vector_o    (vector_o)
    );

endmodule

// File: rtl/irq_bid_arbiter_chk.sv
// Checker: port-level properties of the interrupt bid arbiter, bound to the top.
module irq_bid_arbiter_chk
    import irqarb_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int MSB_W = 3,
    parameter int VEC_W = 8,
    parameter int CH_W  = $clog2(NCH)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCH*NTYPE-1:0]       req_i,
    input logic [NCH*NTYPE-1:0]       mask_i,
    input logic [NCH*NTYPE*MSB_W-1:0] bid_msb_i,
    input logic                       iack_i,
    input logic [1:0]                 vmode_i,
    input logic [VEC_W-1:0]           vec_base_i,
    input logic                       irq_n_o,
    input logic                       cur_valid_o,
    input logic [CH_W-1:0]            cur_ch_o,
    input logic [1:0]                 cur_class_o,
    input logic [2:0]                 cur_other_o,
    input logic [VEC_W-1:0]           vector_o
);

    logic live;
    assign live = |(req_i & mask_i);

    // Priority fields only steer the choice, never the line; keep them observed.
    logic unused_fields;
    assign unused_fields = ^bid_msb_i;

    p_irq_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> !irq_n_o);

    p_irq_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> irq_n_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_i |=> $stable({cur_valid_o, cur_ch_o, cur_class_o, cur_other_o, vector_o}));

    p_ack_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && live) |=> cur_valid_o);

    p_code_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_class_o != 2'b00) |-> (cur_other_o == 3'b000));

    p_vec_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && vmode_i == 2'd0) |=> (vector_o == $past(vec_base_i)));

    p_vec_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && vmode_i != 2'd0) |=> (vector_o[CH_W-1:0] == cur_ch_o));

    p_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && !live) |=> (!cur_valid_o && cur_ch_o == '0 &&
                               cur_class_o == 2'b00 && cur_other_o == 3'b000));

endmodule

bind irq_bid_arbiter irq_bid_arbiter_chk #(
    .NCH(NCH), .MSB_W(MSB_W), .VEC_W(VEC_W), .CH_W(CH_W)
) u_chk (.*);

// File: tb/tb_irq_bid_arbiter.sv
// Scoreboard bench: the driver pushes expected snapshots, the monitor compares.
module tb_irq_bid_arbiter;
    import irqarb_pkg::*;

    localparam int NCH = 8;
    localparam int MW  = 3;
    localparam int VW  = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NCH*NTYPE-1:0]    req = '0;
    logic [NCH*NTYPE-1:0]    mask = '0;
    logic [NCH*NTYPE*MW-1:0] msb = '0;
    logic                    iack = 1'b0;
    logic [1:0]              vmode = 2'd2;
    logic [VW-1:0]           vbase = 8'hA0;
    logic                    irq_n, cv;
    logic [2:0]              cch, coth;
    logic [1:0]              ccls;
    logic [VW-1:0]           vec;

    irq_bid_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .bid_msb_i(msb),
        .iack_i(iack), .vmode_i(vmode), .vec_base_i(vbase),
        .irq_n_o(irq_n), .cur_valid_o(cv), .cur_ch_o(cch),
        .cur_class_o(ccls), .cur_other_o(coth), .vector_o(vec)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          due;
        logic        v;
        logic [2:0]  ch;
        logic [1:0]  cls;
        logic [2:0]  oth;
        logic [7:0]  vec;
        logic        irqn;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    item_t model;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare the head item when its cycle arrives.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            item_t e;
            e = q.pop_front();
            checks++;
            if (cv !== e.v || cch !== e.ch || ccls !== e.cls || coth !== e.oth ||
                vec !== e.vec || irq_n !== e.irqn) begin
                errors++;
                $display("FAIL %s: actual v=%0b ch=%0d cls=%b oth=%b vec=%h irq_n=%0b expected v=%0b ch=%0d cls=%b oth=%b vec=%h irq_n=%0b",
                         e.tag, cv, cch, ccls, coth, vec, irq_n,
                         e.v, e.ch, e.cls, e.oth, e.vec, e.irqn);
            end
        end
    end

    task automatic clr_all();
        req = '0; mask = '0; msb = '0;
    endtask

    task automatic put(int c, int t, int p, bit en);
        req[c*NTYPE+t]            = 1'b1;
        mask[c*NTYPE+t]           = en;
        msb[(c*NTYPE+t)*MW +: MW] = MW'(p);
    endtask

    // Independent reference: largest {priority, channel, kind} among live requests.
    function automatic item_t predict(string tag);
        item_t r;
        logic [8:0] best;
        logic       found;
        logic [2:0] k;
        found = 1'b0; best = '0;
        for (int c = 0; c < NCH; c++)
            for (int t = 0; t < NTYPE; t++)
                if (req[c*NTYPE+t] && mask[c*NTYPE+t]) begin
                    logic [8:0] key;
                    key = {msb[(c*NTYPE+t)*MW +: MW], 3'(c), 3'(t)};
                    if (!found || key > best) best = key;
                    found = 1'b1;
                end
        k = best[2:0];
        r.v   = found;
        r.ch  = found ? best[5:3] : 3'd0;
        r.cls = !found ? 2'b00 : (k == 3'd0) ? 2'b01 : (k == 3'd1) ? 2'b10 : 2'b00;
        r.oth = !found ? 3'b000 : (k == 3'd2) ? 3'b001 : (k == 3'd4) ? 3'b010 :
                (k == 3'd3) ? 3'b011 : (k == 3'd5) ? 3'b100 : 3'b000;
        r.vec = vbase;
        if (vmode != 2'd0) r.vec[2:0] = r.ch;
        if (vmode[1])      r.vec[4:3] = r.cls;
        r.irqn = !found;
        r.tag  = tag;
        return r;
    endfunction

    // Driver: acknowledge now and queue the expected snapshot for the next cycle.
    task automatic ack_expect(string tag);
        @(negedge clk);
        model = predict(tag);
        model.due = cyc + 1;
        q.push_back(model);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
    endtask

    // Driver: no acknowledge; snapshot must hold, irq follows the inputs.
    task automatic hold_expect(string tag);
        item_t r;
        @(negedge clk);
        r = model;
        r.irqn = !(|(req & mask));
        r.tag  = tag;
        r.due  = cyc + 1;
        q.push_back(r);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (irq_n !== 1'b1 || cv !== 1'b0 || cch !== 3'd0 || ccls !== 2'b00 ||
            coth !== 3'b000 || vec !== 8'h00) begin
            errors++;
            $display("FAIL R10 reset: actual irq_n=%0b v=%0b ch=%0d cls=%b oth=%b vec=%h expected 1 0 0 00 000 00",
                     irq_n, cv, cch, ccls, coth, vec);
        end
        model = '{due:0, v:1'b0, ch:3'd0, cls:2'b00, oth:3'b000, vec:8'h00, irqn:1'b1, tag:""};

        // R7 lone change-of-state request on channel 3.
        clr_all(); put(3, 2, 2, 1'b1);
        ack_expect("R7 lone cos ch3");

        // R1 priority field dominates channel number.
        clr_all(); put(1, 5, 5, 1'b1); put(6, 3, 3, 1'b1);
        ack_expect("R1 field beats channel");

        // R2 equal fields: higher channel wins.
        clr_all(); put(2, 4, 4, 1'b1); put(5, 3, 4, 1'b1);
        ack_expect("R2 tie to higher channel");

        // R3 same channel, equal fields: break beats Xon/Xoff.
        clr_all(); put(4, 4, 6, 1'b1); put(4, 5, 6, 1'b1);
        ack_expect("R3 kind tie break wins");

        // R3 / R7 receive beats transmit, receive class code.
        clr_all(); put(0, 0, 1, 1'b1); put(0, 1, 1, 1'b1);
        ack_expect("R3 R7 rx over tx");

        // R7 transmit class code.
        clr_all(); put(7, 0, 7, 1'b1);
        ack_expect("R7 tx class");

        // R7 address match code.
        clr_all(); put(6, 3, 0, 1'b1);
        ack_expect("R7 addr code");

        // R4 masked high bid ignored.
        clr_all(); put(7, 5, 7, 1'b0); put(1, 2, 1, 1'b1);
        ack_expect("R4 masked bid ignored");

        // R4 / R9 only masked requests: line stays high, empty snapshot.
        clr_all(); put(3, 1, 7, 1'b0); put(5, 5, 7, 1'b0);
        hold_expect("R4 masked no irq");
        ack_expect("R9 ack with nothing pending");

        // R8 every vector mode on one winner.
        clr_all(); put(5, 1, 3, 1'b1); vbase = 8'hFF;
        for (int m = 0; m < 4; m++) begin
            vmode = 2'(m);
            ack_expect($sformatf("R8 vector mode %0d", m));
        end
        vmode = 2'd2; vbase = 8'hA0;

        // R6 snapshot holds while requests change; R5 line follows.
        clr_all(); put(2, 5, 4, 1'b1);
        ack_expect("R6 take snapshot");
        clr_all(); put(6, 4, 7, 1'b1);
        hold_expect("R6 hold with new request");

        // R5 line stays low after ack while a request remains, then releases.
        clr_all(); put(1, 3, 2, 1'b1); put(3, 2, 5, 1'b1);
        ack_expect("R5 low after ack");
        mask[3*NTYPE+2] = 1'b0;
        hold_expect("R5 still low one left");
        clr_all();
        hold_expect("R5 high when cleared");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule